// File: doc/BRIEF.md
# Codeword Checksum Generator and Checker

This block works bit-serially on a 64-bit codeword sent as eight bytes, most significant bit first. The codeword holds six data bytes and a 16-bit checksum. The checksum is a 15-bit cyclic remainder followed by one parity bit. The generator polynomial is x^15+x^14+x^13+x^11+x^4+x^2+1, and division is modulo 2.

In transmit mode the 48 data bits pass straight through to the line output. The block then replaces the next 16 bit slots with its own checksum. The remainder goes out first, MSB first, with its final bit inverted. The parity bit comes last.

In receive mode the block does the following:
- It divides the first 63 received bits, with bit 63 inverted.
- It computes the even parity of those 63 bits.
- At bit 64 it raises a checksum-true flag and a one-cycle interrupt pulse when the remainder is zero and the parity matches.

A restart input puts the block at the first bit of a new codeword. While a sync search is in progress, or while the block is disabled, the logic is held idle and bits pass straight through.

Top module: `cw_cksum_unit`

## Requirements
- R1: In transmit mode, positions 48..62 of each codeword carry the remainder of (48 data bits)·x^15 modulo the polynomial (full mask 16'hE815), MSB first, with the last remainder bit (position 62) inverted.
- R2: In transmit mode, position 63 carries a bit that makes the 64-bit codeword contain an even number of ones.
- R3: In transmit mode, positions 0..47 put bit_in on tx_bit unchanged. cks_slot is high exactly at positions 48..63, and bit_in has no effect on tx_bit there.
- R4: In receive mode, when the 64th bit is taken the block sets cks_true to 1 and pulses cks_irq for one cycle, provided the remainder of bits 0..62 (with bit 62 inverted) is zero and bit 63 equals the even parity of bits 0..62. A restart clears cks_true.
- R5: A received codeword with any single bit in error leaves cks_true at 0 and produces no cks_irq.
- R6: Codewords follow each other every 64 accepted bits without a restart. The divider and the parity start from zero for each codeword, so a failing codeword does not affect the next one.
- R7: A high restart makes the next accepted bit position 0. A bit offered in the same cycle as the restart is dropped.
- R8: While sync_search is high: tx_bit equals bit_in, cks_slot is 0, cks_true is 0, and the position is held at 0.
- R9: While enable is low, the block behaves as in R8.
- R10: A cycle with bit_valid low advances nothing.
- R11: After reset: cks_true=0, cks_irq=0 and cks_slot=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Checksum logic enable |
| sync_search | input | 1 | High while a sync word search runs; holds the logic idle |
| tx_mode | input | 1 | 1 = transmit (generate), 0 = receive (check) |
| restart | input | 1 | Realign to the first bit of a codeword |
| bit_valid | input | 1 | A line bit is presented this cycle |
| bit_in | input | 1 | Data bit (transmit) or received bit (receive) |
| tx_bit | output | 1 | Line bit to send in transmit mode |
| cks_slot | output | 1 | Current position is a checksum slot (source should stall) |
| cks_true | output | 1 | Last received codeword passed the check |
| cks_irq | output | 1 | One-cycle pulse on a passing codeword |

## Verification
Six data patterns are run through transmit mode, then looped back in receive mode:
- all zeros, which isolates the inverted remainder bit and the parity;
- all ones;
- a single set bit at each end, which separates MSB-first from LSB-first division;
- two mixed words.

Each looped-back word is then sent again with a flipped remainder bit, and again with a flipped parity bit. These two cases separate the zero-remainder test from the parity comparison. Directed cases cover:
- back-to-back codewords after a failure;
- a restart in mid-word;
- pauses between bits;
- the idle behaviour under sync search or disable.

// File: rtl/cw_cksum_pkg.sv
package cw_cksum_pkg;
   localparam int unsigned CKS_CRC_W      = 15;
   localparam logic [14:0] CKS_POLY_LOW   = 15'h6815;
   localparam int unsigned CKS_DATA_BYTES = 6;
   localparam int unsigned CKS_BYTE_W     = 8;

   typedef enum logic [1:0] {
      SEG_DATA = 2'd0,
      SEG_REM  = 2'd1,
      SEG_PAR  = 2'd2
   } cks_seg_e;
endpackage

// File: rtl/cw_lfsr_step.sv
module cw_lfsr_step #(
   parameter int unsigned W        = 15,
   parameter logic [W-1:0] POLY    = '0
) (
   input  logic [W-1:0] cur,
   input  logic         din,
   output logic [W-1:0] nxt
);
   logic fb;
   assign fb = din ^ cur[W-1];

   for (genvar i = 0; i < W; i++) begin : g_tap
      if (i == 0) begin : g_lsb
         assign nxt[0] = fb & POLY[0];
      end else begin : g_mid
         assign nxt[i] = cur[i-1] ^ (fb & POLY[i]);
      end
   end
endmodule

// File: rtl/cw_pos_ctr.sv
module cw_pos_ctr #(
   parameter int unsigned LEN = 64,
   localparam int unsigned PW = $clog2(LEN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          adv,
   output logic [PW-1:0] pos
);
   localparam logic [PW-1:0] LAST = PW'(LEN - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pos <= '0;
      else if (clear)   pos <= '0;
      else if (adv)     pos <= (pos == LAST) ? '0 : pos + 1'b1;
   end
endmodule

// File: rtl/cw_cksum_unit.sv
module cw_cksum_unit #(
   parameter int unsigned DATA_BYTES = cw_cksum_pkg::CKS_DATA_BYTES,
   parameter int unsigned BYTE_W     = cw_cksum_pkg::CKS_BYTE_W,
   parameter int unsigned CRC_W      = cw_cksum_pkg::CKS_CRC_W,
   parameter logic [CRC_W-1:0] POLY  = cw_cksum_pkg::CKS_POLY_LOW
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic sync_search,
   input  logic tx_mode,
   input  logic restart,
   input  logic bit_valid,
   input  logic bit_in,
   output logic tx_bit,
   output logic cks_slot,
   output logic cks_true,
   output logic cks_irq
);
   import cw_cksum_pkg::*;

   localparam int unsigned DATA_W = DATA_BYTES * BYTE_W;
   localparam int unsigned WORD_W = DATA_W + CRC_W + 1;
   localparam int unsigned PW     = $clog2(WORD_W);
   localparam logic [PW-1:0] REM_FIRST = PW'(DATA_W);
   localparam logic [PW-1:0] REM_LAST  = PW'(DATA_W + CRC_W - 1);
   localparam logic [PW-1:0] PAR_POS   = PW'(WORD_W - 1);

   initial begin
      if (WORD_W % BYTE_W != 0)
         $error("codeword width %0d is not a whole number of bytes", WORD_W);
      if (POLY[0] != 1'b1)
         $error("polynomial must have a constant term");
      if (CRC_W < 2)
         $error("remainder width too small");
   end

   logic          active, adv, clr;
   logic [PW-1:0] pos;
   cks_seg_e      seg;
   logic          first, last_rem;
   logic [CRC_W-1:0] div_q, div_cur, div_nxt;
   logic          par_q, par_cur;
   logic          feed, line_bit, pass;

   assign active = enable & ~sync_search;
   assign clr    = restart | ~active;
   assign adv    = bit_valid & active & ~restart;

   cw_pos_ctr #(.LEN(WORD_W)) u_pos (
      .clk(clk), .rst_n(rst_n), .clear(clr), .adv(adv), .pos(pos)
   );

   always_comb begin
      if (pos < REM_FIRST)    seg = SEG_DATA;
      else if (pos == PAR_POS) seg = SEG_PAR;
      else                    seg = SEG_REM;
   end

   assign first    = (pos == '0);
   assign last_rem = (pos == REM_LAST);
   assign div_cur  = first ? '0 : div_q;
   assign par_cur  = first ? 1'b0 : par_q;

   // transmit line bit
   always_comb begin
      tx_bit = bit_in;
      if (active && tx_mode) begin
         unique case (seg)
            SEG_DATA: tx_bit = bit_in;
            SEG_REM:  tx_bit = div_cur[CRC_W-1] ^ last_rem;
            SEG_PAR:  tx_bit = par_cur;
            default:  tx_bit = bit_in;
         endcase
      end
   end

   assign cks_slot = active & tx_mode & (seg != SEG_DATA);

   // divider input: data in transmit, shifting out remainder in its slots
   always_comb begin
      if (tx_mode) feed = (seg == SEG_DATA) ? bit_in : div_cur[CRC_W-1];
      else         feed = bit_in ^ last_rem;
   end

   assign line_bit = tx_mode ? tx_bit : bit_in;

   cw_lfsr_step #(.W(CRC_W), .POLY(POLY)) u_step (
      .cur(div_cur), .din(feed), .nxt(div_nxt)
   );

   assign pass = (div_cur == '0) && (par_cur == bit_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         par_q <= 1'b0;
      end else if (clr) begin
         div_q <= '0;
         par_q <= 1'b0;
      end else if (adv) begin
         div_q <= div_nxt;
         par_q <= par_cur ^ line_bit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cks_true <= 1'b0;
         cks_irq  <= 1'b0;
      end else begin
         cks_irq <= 1'b0;
         if (clr) begin
            cks_true <= 1'b0;
         end else if (adv && !tx_mode && seg == SEG_PAR) begin
            cks_true <= pass;
            cks_irq  <= pass;
         end
      end
   end
endmodule

// File: rtl/cw_cksum_unit_chk.sv
module cw_cksum_unit_chk #(
   parameter int unsigned PW     = 6,
   parameter int unsigned DATA_W = 48
) (
   input logic          clk,
   input logic          rst_n,
   input logic          enable,
   input logic          sync_search,
   input logic          tx_mode,
   input logic          restart,
   input logic          bit_valid,
   input logic          bit_in,
   input logic          tx_bit,
   input logic          cks_true,
   input logic          cks_irq,
   input logic [PW-1:0] pos
);
   p_irq_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cks_irq |-> cks_true);
   p_irq_rx_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cks_irq |-> $past(!tx_mode));
   p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cks_irq |=> !cks_irq);
   p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_search || !enable) |=> (!cks_true && !cks_irq && pos == '0));
   p_restart_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (pos == '0));
   p_pos_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_valid && !restart && enable && !sync_search) |=> $stable(pos));
   p_data_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !sync_search && tx_mode && pos < PW'(DATA_W)) |-> (tx_bit == bit_in));
endmodule

bind cw_cksum_unit cw_cksum_unit_chk #(.PW(PW), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .sync_search(sync_search),
   .tx_mode(tx_mode), .restart(restart), .bit_valid(bit_valid), .bit_in(bit_in),
   .tx_bit(tx_bit), .cks_true(cks_true), .cks_irq(cks_irq), .pos(pos)
);

// File: tb/cw_cksum_unit_tb.sv
`timescale 1ns/1ps
module cw_cksum_unit_tb_top;
   logic clk = 1'b0, rst_n = 1'b0;
   logic enable = 1'b0, sync_search = 1'b0, tx_mode = 1'b0;
   logic restart = 1'b0, bit_valid = 1'b0, bit_in = 1'b0;
   logic tx_bit, cks_slot, cks_true, cks_irq;
   int   n_chk = 0, n_bad = 0;
   logic irq_seen;

   always #2.5 clk = ~clk;

   cw_cksum_unit dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .sync_search(sync_search),
      .tx_mode(tx_mode), .restart(restart), .bit_valid(bit_valid),
      .bit_in(bit_in), .tx_bit(tx_bit), .cks_slot(cks_slot),
      .cks_true(cks_true), .cks_irq(cks_irq)
   );

   localparam int NV = 6;
   localparam logic [47:0] VEC [NV] = '{
      48'h0000_0000_0000, 48'hFFFF_FFFF_FFFF, 48'h8000_0000_0000,
      48'h0000_0000_0001, 48'h1234_5678_9ABC, 48'hA5A5_5A5A_C3C3 };

   function automatic logic [15:0] ref_cks(input logic [47:0] d);
      logic [62:0] v;
      logic [14:0] rem;
      logic        par;
      v = {d, 15'b0};
      for (int i = 62; i >= 15; i--)
         if (v[i]) v[i-:16] = v[i-:16] ^ 16'hE815;
      rem    = v[14:0];
      rem[0] = ~rem[0];
      par    = (^d) ^ (^rem);
      return {rem, par};
   endfunction

   task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b, input int gap, output logic tb, output logic sl);
      for (int g = 0; g < gap; g++) begin
         @(negedge clk); bit_valid = 1'b0; bit_in = ~bit_in;
      end
      @(negedge clk);
      bit_valid = 1'b1; bit_in = b;
      #0.5;
      tb = tx_bit; sl = cks_slot;
      @(posedge clk); #0.5;
      bit_valid = 1'b0;
      if (cks_irq) irq_seen = 1'b1;
   endtask

   task automatic do_restart();
      @(negedge clk); restart = 1'b1;
      @(posedge clk); #0.5; restart = 1'b0;
   endtask

   // transmit a data word, return the full line codeword
   task automatic tx_word(input logic [47:0] d, input int gap, output logic [63:0] w, output logic slot_ok);
      logic tb, sl;
      slot_ok = 1'b1;
      for (int i = 0; i < 64; i++) begin
         send_bit(i < 48 ? d[47-i] : 1'b1, gap, tb, sl);
         w[63-i] = tb;
         if (sl != (i >= 48)) slot_ok = 1'b0;
      end
   endtask

   task automatic rx_word(input logic [63:0] w, input int gap);
      logic tb, sl;
      irq_seen = 1'b0;
      for (int i = 0; i < 64; i++) send_bit(w[63-i], gap, tb, sl);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [63:0] w, w2;
      logic        sok, tb, sl;
      logic [15:0] e;
      repeat (3) @(posedge clk);
      #0.5;
      // R11 reset state
      check(!cks_true && !cks_irq && !cks_slot, "R11 reset", {cks_true, cks_irq, cks_slot}, 0);
      rst_n = 1'b1;
      enable = 1'b1;

      for (int v = 0; v < NV; v++) begin
         e = ref_cks(VEC[v]);
         tx_mode = 1'b1; do_restart();
         tx_word(VEC[v], v % 3, w, sok);
         check(w[63:16] == VEC[v], "R3 data passthrough", w[63:16], VEC[v]);
         check(sok, "R3 slot timing", sok, 1);
         check(w[15:1] == e[15:1], "R1 remainder", w[15:1], e[15:1]);
         check(w[0] == e[0] && ^w == 1'b0, "R2 parity", w[0], e[0]);
         tx_mode = 1'b0; do_restart();
         check(!cks_true, "R4 restart clears flag", cks_true, 0);
         rx_word(w, v % 2);
         check(cks_true && irq_seen, "R4 good word", {cks_true, irq_seen}, 2'b11);
         w2 = w; w2[5 + v] = ~w2[5 + v];
         rx_word(w2, 0);
         check(!cks_true && !irq_seen, "R5 remainder bit error", {cks_true, irq_seen}, 0);
         w2 = w; w2[0] = ~w2[0];
         rx_word(w2, 0);
         check(!cks_true && !irq_seen, "R5 parity bit error", {cks_true, irq_seen}, 0);
         // R6 next word right after a failing one, no restart
         rx_word(w, 0);
         check(cks_true && irq_seen, "R6 back to back", {cks_true, irq_seen}, 2'b11);
      end

      // R7 restart in mid word
      e = ref_cks(VEC[4]);
      w = {VEC[4], e};
      rx_word(w, 0);
      for (int i = 0; i < 21; i++) send_bit(i[0], 0, tb, sl);
      do_restart();
      rx_word(w, 0);
      check(cks_true && irq_seen, "R7 realign", {cks_true, irq_seen}, 2'b11);

      // R10 long pauses with bit_in toggling
      rx_word(w, 4);
      check(cks_true, "R10 idle cycles", cks_true, 1);

      // R8 sync search: passthrough, no slot, flag cleared, position held
      sync_search = 1'b1; tx_mode = 1'b1;
      sok = 1'b1;
      for (int i = 0; i < 64; i++) begin
         send_bit(i[1], 0, tb, sl);
         if (tb != i[1] || sl) sok = 1'b0;
      end
      check(sok && !cks_true, "R8 sync search idle", {sok, cks_true}, 2'b10);
      sync_search = 1'b0; tx_mode = 1'b0;
      rx_word(w, 0);
      check(cks_true, "R8 held at position 0", cks_true, 1);

      // R9 disabled
      enable = 1'b0; tx_mode = 1'b1;
      sok = 1'b1;
      for (int i = 0; i < 64; i++) begin
         send_bit(~i[0], 0, tb, sl);
         if (tb != ~i[0] || sl) sok = 1'b0;
      end
      check(sok && !cks_true, "R9 disabled idle", {sok, cks_true}, 2'b10);
      enable = 1'b1; tx_mode = 1'b0;
      rx_word(w, 0);
      check(cks_true, "R9 resume at position 0", cks_true, 1);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule